// File: doc/BRIEF.md
# Bridge Data Parity Error Handler

This block watches the data phases on both sides of a two-port PCI-to-PCI bridge and decides what happens when the even parity over a data phase is wrong. Each side delivers its address/data word and byte enables when a data phase completes. One clock later it delivers the parity bit that covers that phase. The block then reports an error on the correct side, or stays silent.

Two error origins are handled:
- **Initiator bus error.** The error is seen on the bus that started the transaction. The block records it in that side's detected status and pulses that side's PERR, if that side's response enable allows it. It passes the received parity to the opposite bus unchanged, so the bad condition reaches the target. For a non-posted write it flags that the write status must stay in the queue.
- **Passed-back error.** The error shows up only on the target bus. The block records it in the target side's status. It reports it on the initiator side only when both response enables are set.

PERR is an active-low, one-clock pulse per bad data phase. It falls in the second clock after the data phase. The pin is then driven high for one clock and released; the release is modelled as an output enable. Direction and posted/non-posted context are captured from the data-phase cycle.

Top module: `pci_bridge_perr_unit`

## Requirements
- R1: While rst_ni is low, and right after it, both status bits, hold_o and fwd_vld_o are 0, both PERR outputs are 1, and both output enables are 0.
- R2: A data phase presented with valid in clock T is checked against the parity input of the same side in clock T+1. It is in error when the XOR of the 32 AD bits, the 4 byte-enable bits and that parity bit is 1.
- R3: An error on the initiator bus drives that side's PERR low in clock T+2, but only if that side's enable is set in clock T+1. The initiator is primary when dir_i=0 (downstream) and secondary when dir_i=1 (upstream). The primary enable is p_per_en_i and the secondary enable is s_per_en_i.
- R4: An error on the initiator bus sets the initiator side's detected status bit in clock T+2.
- R5: An error on the target bus, with no initiator-bus error in the same clock, sets the target side's detected status bit in clock T+2.
- R6: Such a passed-back error drives the initiator side's PERR low in clock T+2, only when p_per_en_i and s_per_en_i are both 1. The target side's PERR is never driven.
- R7: PERR is low for exactly one clock per erroneous phase. Its output enable is 1 while PERR is low and for one clock after, with PERR high, and 0 otherwise.
- R8: Detected status bits are sticky. A clear strobe (p_clr_i, s_clr_i) clears its bit at the next edge, but a set in the same clock wins.
- R9: For every checked initiator-side phase, fwd_vld_o is 1 in clock T+2 and fwd_par_o equals the initiator's received parity bit, bad or good.
- R10: hold_o is 1 in clock T+2 exactly when an initiator-bus error occurs on a non-posted transaction. It is never set for posted transactions.
- R11: dir_i and posted_i are taken from the most recent clock where either side had a valid data phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| dir_i | input | 1 | 0 downstream (primary initiates), 1 upstream |
| posted_i | input | 1 | 1 posted write, 0 non-posted |
| p_per_en_i | input | 1 | Primary command parity-error-response enable |
| s_per_en_i | input | 1 | Secondary bridge-control parity-error-response enable |
| p_valid_i | input | 1 | Primary data phase completes this clock |
| p_ad_i | input | 32 | Primary AD word |
| p_cbe_i | input | 4 | Primary byte enables |
| p_par_i | input | 1 | Primary parity, one clock after its phase |
| s_valid_i | input | 1 | Secondary data phase completes this clock |
| s_ad_i | input | 32 | Secondary AD word |
| s_cbe_i | input | 4 | Secondary byte enables |
| s_par_i | input | 1 | Secondary parity, one clock after its phase |
| p_clr_i | input | 1 | Write-one-to-clear strobe for primary status |
| s_clr_i | input | 1 | Write-one-to-clear strobe for secondary status |
| p_perr_no | output | 1 | Primary PERR, active low |
| p_perr_oe_o | output | 1 | Primary PERR drive enable |
| s_perr_no | output | 1 | Secondary PERR, active low |
| s_perr_oe_o | output | 1 | Secondary PERR drive enable |
| p_det_o | output | 1 | Primary parity-error-detected status |
| s_det_o | output | 1 | Secondary parity-error-detected status |
| fwd_par_o | output | 1 | Parity passed to the opposite bus |
| fwd_vld_o | output | 1 | fwd_par_o is meaningful |
| hold_o | output | 1 | Keep the non-posted write status queued |

## Verification
The assertions rely on three conditions:
- The parity bit arrives exactly one clock after its data phase.
- The enables are sampled in that parity clock.
- dir_i and posted_i describe the transaction that owns the phase being checked.

The stimulus respects these conditions. It drives every parity bit from a one-deep pending slot per side, filled in the phase clock. It changes dir_i and posted_i only between transactions, except in one deliberate case: the phase has already latched them, and the context is flipped during the parity clock.

// File: rtl/pbp_pkg.sv
package pbp_pkg;
  localparam int NSIDE  = 2;
  localparam int SIDE_P = 0;
  localparam int SIDE_S = 1;

  typedef enum logic {DIR_DOWN = 1'b0, DIR_UP = 1'b1} pbp_dir_e;

  typedef struct packed {
    pbp_dir_e dir;
    logic     posted;
  } pbp_ctx_t;
endpackage

// File: rtl/pbp_par_chk.sv
module pbp_par_chk #(
  parameter int DATA_W = 32,
  parameter int BE_W   = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [DATA_W-1:0] ad_i,
  input  logic [BE_W-1:0]   cbe_i,
  input  logic              par_i,
  output logic              chk_o,
  output logic              err_o
);
  logic pend_q, dpar_q;

  // only the data parity is kept; the word itself is not needed later
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= 1'b0;
      dpar_q <= 1'b0;
    end else begin
      pend_q <= valid_i;
      if (valid_i) dpar_q <= ^{ad_i, cbe_i};
    end
  end

  assign chk_o = pend_q;
  assign err_o = pend_q & (dpar_q ^ par_i);

  assert_chk_follows_phase_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    chk_o |-> $past(valid_i));
endmodule

// File: rtl/pbp_perr_drv.sv
module pbp_perr_drv (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic fire_i,
  output logic perr_no,
  output logic oe_o
);
  logic perr_nq, oe_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      perr_nq <= 1'b1;
      oe_q    <= 1'b0;
    end else begin
      perr_nq <= ~fire_i;
      oe_q    <= fire_i | ~perr_nq;   // keep driving one clock after the low
    end
  end

  assign perr_no = perr_nq;
  assign oe_o    = oe_q;

  assert_low_is_driven_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !perr_no |-> oe_o);
  assert_high_after_low_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !perr_no && !fire_i |=> perr_no && oe_o);
  assert_release_after_high_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(oe_o) |-> perr_no);
endmodule

// File: rtl/pbp_status.sv
module pbp_status (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic det_o
);
  logic det_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    det_q <= 1'b0;
    else if (set_i) det_q <= 1'b1;
    else if (clr_i) det_q <= 1'b0;
  end

  assign det_o = det_q;

  assert_sticky_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    det_o && !clr_i |=> det_o);
  assert_set_wins_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_i |=> det_o);
endmodule

// File: rtl/pci_bridge_perr_unit.sv
module pci_bridge_perr_unit
  import pbp_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int BE_W   = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              dir_i,
  input  logic              posted_i,
  input  logic              p_per_en_i,
  input  logic              s_per_en_i,
  input  logic              p_valid_i,
  input  logic [DATA_W-1:0] p_ad_i,
  input  logic [BE_W-1:0]   p_cbe_i,
  input  logic              p_par_i,
  input  logic              s_valid_i,
  input  logic [DATA_W-1:0] s_ad_i,
  input  logic [BE_W-1:0]   s_cbe_i,
  input  logic              s_par_i,
  input  logic              p_clr_i,
  input  logic              s_clr_i,
  output logic              p_perr_no,
  output logic              p_perr_oe_o,
  output logic              s_perr_no,
  output logic              s_perr_oe_o,
  output logic              p_det_o,
  output logic              s_det_o,
  output logic              fwd_par_o,
  output logic              fwd_vld_o,
  output logic              hold_o
);
  logic              valid [NSIDE];
  logic [DATA_W-1:0] ad    [NSIDE];
  logic [BE_W-1:0]   cbe   [NSIDE];
  logic              par   [NSIDE];
  logic              en    [NSIDE];
  logic              clr   [NSIDE];
  logic              chk   [NSIDE];
  logic              err   [NSIDE];
  logic              fire  [NSIDE];
  logic              set   [NSIDE];
  logic              perr_n[NSIDE];
  logic              oe    [NSIDE];
  logic              det   [NSIDE];

  assign valid[SIDE_P] = p_valid_i;  assign valid[SIDE_S] = s_valid_i;
  assign ad[SIDE_P]    = p_ad_i;     assign ad[SIDE_S]    = s_ad_i;
  assign cbe[SIDE_P]   = p_cbe_i;    assign cbe[SIDE_S]   = s_cbe_i;
  assign par[SIDE_P]   = p_par_i;    assign par[SIDE_S]   = s_par_i;
  assign en[SIDE_P]    = p_per_en_i; assign en[SIDE_S]    = s_per_en_i;
  assign clr[SIDE_P]   = p_clr_i;    assign clr[SIDE_S]   = s_clr_i;

  // transaction context captured in the data-phase clock
  pbp_ctx_t ctx_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ctx_q <= '{dir: DIR_DOWN, posted: 1'b0};
    else if (p_valid_i | s_valid_i) ctx_q <= '{dir: pbp_dir_e'(dir_i), posted: posted_i};
  end

  logic ini, init_err, back_err, both_en;
  assign ini      = (ctx_q.dir == DIR_UP);   // 0: primary initiates, 1: secondary
  assign init_err = err[ini];
  assign back_err = err[~ini] & ~init_err;
  assign both_en  = p_per_en_i & s_per_en_i;

  for (genvar g = 0; g < NSIDE; g++) begin : g_side
    localparam bit SIDE = (g == SIDE_S);

    pbp_par_chk #(.DATA_W(DATA_W), .BE_W(BE_W)) u_chk (
      .clk_i, .rst_ni,
      .valid_i(valid[g]), .ad_i(ad[g]), .cbe_i(cbe[g]), .par_i(par[g]),
      .chk_o(chk[g]), .err_o(err[g])
    );

    always_comb begin
      if (SIDE == ini) begin
        fire[g] = (init_err & en[g]) | (back_err & both_en);
        set[g]  = init_err;
      end else begin
        fire[g] = 1'b0;
        set[g]  = back_err;
      end
    end

    pbp_perr_drv u_drv (
      .clk_i, .rst_ni, .fire_i(fire[g]), .perr_no(perr_n[g]), .oe_o(oe[g])
    );

    pbp_status u_stat (
      .clk_i, .rst_ni, .set_i(set[g]), .clr_i(clr[g]), .det_o(det[g])
    );
  end

  logic fwd_par_q, fwd_vld_q, hold_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fwd_par_q <= 1'b0;
      fwd_vld_q <= 1'b0;
      hold_q    <= 1'b0;
    end else begin
      fwd_vld_q <= chk[ini];
      if (chk[ini]) fwd_par_q <= par[ini];   // passed through, never regenerated
      hold_q    <= init_err & ~ctx_q.posted;
    end
  end

  assign p_perr_no   = perr_n[SIDE_P];
  assign p_perr_oe_o = oe[SIDE_P];
  assign s_perr_no   = perr_n[SIDE_S];
  assign s_perr_oe_o = oe[SIDE_S];
  assign p_det_o     = det[SIDE_P];
  assign s_det_o     = det[SIDE_S];
  assign fwd_par_o   = fwd_par_q;
  assign fwd_vld_o   = fwd_vld_q;
  assign hold_o      = hold_q;

  assert_hold_on_checked_phase_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hold_o |-> fwd_vld_o);
  assert_p_perr_needs_enable_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !p_perr_no && $past(!p_perr_no) == 1'b0 |-> $past(p_per_en_i));
  assert_s_perr_needs_enable_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !s_perr_no && $past(!s_perr_no) == 1'b0 |-> $past(s_per_en_i));
  assert_perr_one_side_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(!p_perr_no && !s_perr_no && $past(!p_perr_no) == 1'b0 && $past(!s_perr_no) == 1'b0));
  assert_status_needs_check_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(p_det_o) || $rose(s_det_o) |-> $past(chk[SIDE_P] | chk[SIDE_S]));
endmodule

// File: tb/pci_bridge_perr_unit_tb_top.sv
module pci_bridge_perr_unit_tb_top;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic dir = 0, posted = 0, p_en = 0, s_en = 0;
  logic p_valid = 0, s_valid = 0, p_par = 0, s_par = 0, p_clr = 0, s_clr = 0;
  logic [31:0] p_ad = 0, s_ad = 0;
  logic [3:0]  p_cbe = 0, s_cbe = 0;
  logic p_perr_n, p_oe, s_perr_n, s_oe, p_det, s_det, fwd_par, fwd_vld, hold;

  int n_chk = 0, n_err = 0;
  bit pend_ppar = 0, pend_spar = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pci_bridge_perr_unit dut_i (
    .clk_i(clk), .rst_ni(rst_n), .dir_i(dir), .posted_i(posted),
    .p_per_en_i(p_en), .s_per_en_i(s_en),
    .p_valid_i(p_valid), .p_ad_i(p_ad), .p_cbe_i(p_cbe), .p_par_i(p_par),
    .s_valid_i(s_valid), .s_ad_i(s_ad), .s_cbe_i(s_cbe), .s_par_i(s_par),
    .p_clr_i(p_clr), .s_clr_i(s_clr),
    .p_perr_no(p_perr_n), .p_perr_oe_o(p_oe), .s_perr_no(s_perr_n), .s_perr_oe_o(s_oe),
    .p_det_o(p_det), .s_det_o(s_det), .fwd_par_o(fwd_par), .fwd_vld_o(fwd_vld), .hold_o(hold)
  );

  function automatic bit even_par(logic [31:0] a, logic [3:0] b);
    return bit'(($countones(a) + $countones(b)) % 2);
  endfunction

  // ---------------- reference model ----------------
  bit m_pv, m_sv, m_pdp, m_sdp, m_dir, m_post;
  bit e_pn = 1, e_poe, e_sn = 1, e_soe, e_pdet, e_sdet, e_fpar, e_fvld, e_hold;

  always @(posedge clk) begin
    if (!rst_n) begin
      {m_pv, m_sv, m_pdp, m_sdp, m_dir, m_post} = '0;
      e_pn = 1; e_sn = 1;
      {e_poe, e_soe, e_pdet, e_sdet, e_fpar, e_fvld, e_hold} = '0;
    end else begin
      bit perr_p, perr_s, ie, te, ie_side_s, fp, fs, np, ns;
      perr_p = m_pv && (m_pdp != p_par);
      perr_s = m_sv && (m_sdp != s_par);
      ie_side_s = m_dir;
      ie = ie_side_s ? perr_s : perr_p;
      te = (ie_side_s ? perr_p : perr_s) && !ie;
      fp = 0; fs = 0;
      if (ie_side_s) fs = (ie && s_en) || (te && p_en && s_en);
      else           fp = (ie && p_en) || (te && p_en && s_en);
      np = ie_side_s ? te : ie;
      ns = ie_side_s ? ie : te;
      e_poe = fp || !e_pn;  e_pn = !fp;
      e_soe = fs || !e_sn;  e_sn = !fs;
      e_pdet = np ? 1 : (p_clr ? 0 : e_pdet);
      e_sdet = ns ? 1 : (s_clr ? 0 : e_sdet);
      e_fvld = ie_side_s ? m_sv : m_pv;
      if (e_fvld) e_fpar = ie_side_s ? s_par : p_par;
      e_hold = ie && !m_post;
      m_pv = p_valid; m_sv = s_valid;
      if (p_valid) m_pdp = even_par(p_ad, p_cbe);
      if (s_valid) m_sdp = even_par(s_ad, s_cbe);
      if (p_valid || s_valid) begin m_dir = dir; m_post = posted; end
    end
  end

  task automatic chk(string tag, logic act, logic exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%b expected=%b at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (rst_n) begin
    chk("R3/R6 p_perr_no", p_perr_n, e_pn);
    chk("R3/R6 s_perr_no", s_perr_n, e_sn);
    chk("R7 p_perr_oe", p_oe, e_poe);
    chk("R7 s_perr_oe", s_oe, e_soe);
    chk("R4/R5/R8 p_det", p_det, e_pdet);
    chk("R4/R5/R8 s_det", s_det, e_sdet);
    chk("R9 fwd_vld", fwd_vld, e_fvld);
    if (e_fvld) chk("R9 fwd_par", fwd_par, e_fpar);
    chk("R10 hold", hold, e_hold);
  end

  // one clock of stimulus; parity for last clock's phase goes out now (R2)
  task automatic cyc(bit pv, bit pbad, bit sv, bit sbad);
    @(negedge clk);
    p_par = pend_ppar; s_par = pend_spar;
    p_valid = pv; s_valid = sv;
    p_clr = 0; s_clr = 0;
    if (pv) begin p_ad = $urandom; p_cbe = 4'($urandom); pend_ppar = even_par(p_ad, p_cbe) ^ pbad; end
    if (sv) begin s_ad = $urandom; s_cbe = 4'($urandom); pend_spar = even_par(s_ad, s_cbe) ^ sbad; end
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) cyc(0, 0, 0, 0);
  endtask

  task automatic clear(bit cp, bit cs);
    @(negedge clk);
    p_par = pend_ppar; s_par = pend_spar; p_valid = 0; s_valid = 0;
    p_clr = cp; s_clr = cs;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_err++; n_chk++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1 reset state
    chk("R1 p_perr_no", p_perr_n, 1); chk("R1 s_perr_no", s_perr_n, 1);
    chk("R1 p_oe", p_oe, 0);          chk("R1 s_oe", s_oe, 0);
    chk("R1 p_det", p_det, 0);        chk("R1 s_det", s_det, 0);
    chk("R1 hold", hold, 0);          chk("R1 fwd_vld", fwd_vld, 0);
    rst_n = 1;
    idle(2);
    // downstream posted, bad primary parity, enable on: R3 R4 R9
    dir = 0; posted = 1; p_en = 1; s_en = 0;
    cyc(1, 1, 0, 0); idle(4);
    // same with enable off: status only
    p_en = 0; cyc(1, 1, 0, 0); idle(4);
    clear(1, 1); idle(1);
    // back-to-back errors, R7 consecutive lows
    p_en = 1; cyc(1, 1, 0, 0); cyc(1, 1, 0, 0); cyc(1, 0, 0, 0); idle(4);
    // non-posted downstream error: R10
    posted = 0; cyc(1, 1, 0, 0); cyc(1, 0, 0, 0); idle(4);
    clear(1, 1); idle(1);
    // passed-back downstream (secondary target error), R5 R6 with enables
    posted = 1; p_en = 1; s_en = 0; cyc(0, 0, 1, 1); idle(4);
    s_en = 1; cyc(0, 0, 1, 1); idle(4);
    clear(1, 1); idle(1);
    // upstream: secondary initiates
    dir = 1; s_en = 1; p_en = 0; cyc(0, 0, 1, 1); idle(4);
    cyc(1, 1, 0, 0); idle(4);
    p_en = 1; cyc(1, 1, 0, 0); idle(4);
    // both sides bad same clock: initiator wins, no passed-back
    cyc(1, 1, 1, 1); idle(4);
    // set and clear in same clock: set wins (R8)
    clear(1, 1); cyc(1, 1, 0, 0); clear(1, 0); idle(4);
    // R11: context flips during the parity clock
    dir = 0; posted = 0;
    cyc(1, 1, 0, 0);
    @(negedge clk); p_par = pend_ppar; p_valid = 0; dir = 1; posted = 1;
    idle(4);
    // random mix
    for (int k = 0; k < 3000; k++) begin
      if (k % 25 == 0) begin dir = $urandom; posted = $urandom; p_en = $urandom; s_en = $urandom; end
      if ($urandom % 10 == 0) clear($urandom, $urandom);
      else cyc($urandom, ($urandom % 4) == 0, $urandom, ($urandom % 4) == 0);
    end
    idle(4);
    // reset mid-run returns to R1 state
    rst_n = 0; @(negedge clk);
    chk("R1 p_det after reset", p_det, 0); chk("R1 s_det after reset", s_det, 0);
    chk("R1 p_perr_no after reset", p_perr_n, 1);
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule